// File: doc/BRIEF.md
# GPIO Event and Interrupt Detector

This block watches a bank of general-purpose input bits and turns activity on them into sticky per-pin event flags and one interrupt line. It takes the input value after masking and polarity correction, together with that value as it was one sample earlier. Each pin has its own detection mode. A pin can react to a high level or to a rising change. In change mode it can also react to both directions.

Detected events set bits in a status vector. A status bit stays set until software writes a 1 to that position through a clear strobe. An enable vector selects which status bits may raise the interrupt. The interrupt is a registered OR of the enabled status bits.

A level-mode pin whose input stays high sets its status bit again on every cycle. As a result, clearing that bit has no lasting effect until the input drops.

Top module: `gpio_event_detect`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every status bit is 0 and the interrupt output is 0.
- R2: A pin whose mode bit is 0 (level mode) has its status bit read as 1 after any clock edge at which its current input bit was 1.
- R3: A pin whose mode bit is 1 and whose both-edge bit is 0 sets its status bit at a clock edge when the previous input bit is 0 and the current one is 1. A change from 1 to 0 leaves the bit unchanged.
- R4: A pin whose mode bit is 1 and whose both-edge bit is 1 sets its status bit at a clock edge when the previous and current input bits differ, in either direction.
- R5: A status bit, once set, stays set across later clock edges until it is cleared, whatever the inputs do.
- R6: At a clock edge where the clear strobe is 1, every status bit whose position holds a 1 in the clear mask becomes 0, unless R7 or R8 applies. Positions holding 0 in the mask are unaffected. When the strobe is 0, the mask has no effect.
- R7: Clearing a level-mode bit while its input is still 1 leaves the bit reading 1.
- R8: When a clear and a new event hit the same bit at the same clock edge, the bit ends up set.
- R9: The interrupt output at each clock edge takes the OR of (status AND enable) as it stood just before that edge. It therefore falls one edge after the last enabled status bit is cleared.
- R10: A status bit whose enable bit is 0 never raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_now | input | NPINS | Masked, polarity-corrected input value at this sample |
| din_last | input | NPINS | The same value one sample earlier |
| mode_edge | input | NPINS | Per pin: 0 = level mode, 1 = change mode |
| mode_any | input | NPINS | Per pin in change mode: 1 = both directions, 0 = rising only |
| evt_en | input | NPINS | Per-pin interrupt enable |
| clr_we | input | 1 | Clear strobe for the status vector |
| clr_mask | input | NPINS | Write-1-to-clear mask, used when clr_we is 1 |
| evt_stat | output | NPINS | Sticky event status |
| irq | output | 1 | Registered interrupt request |

## Verification
The bound checker enforces the following on every cycle:
- A level-high pin, a rising pin or a changing both-edge pin always ends up with its status set.
- No set bit disappears unless its clear mask bit was applied.
- The interrupt always equals the enabled OR of the previous status.

Only the bench scenarios can show the following:
- A falling change in rising-only mode really leaves a cleared bit at 0.
- A clear with no event really empties the bit.
- The collision and level-reassert cases behave as intended under directed sequences.
- Disabled bits keep the interrupt low.

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din_now,
  input  logic [NPINS-1:0] din_last,
  input  logic [NPINS-1:0] mode_edge,
  input  logic [NPINS-1:0] mode_any,
  input  logic [NPINS-1:0] evt_en,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] evt_stat,
  output logic             irq
);

  logic [NPINS-1:0] moved, hit_lvl, hit_any, hit_rise, hits, keep;

  assign moved    = din_now ^ din_last;
  assign hit_lvl  = din_now & ~mode_edge;
  assign hit_any  = moved & mode_edge & mode_any;
  assign hit_rise = moved & din_now & mode_edge;
  assign hits     = hit_lvl | hit_any | hit_rise;
  assign keep     = clr_we ? (evt_stat & ~clr_mask) : evt_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_stat <= '0;
      irq      <= 1'b0;
    end else begin
      evt_stat <= keep | hits;
      irq      <= |(evt_stat & evt_en);
    end
  end

endmodule

module gpio_event_detect_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] din_now,
  input logic [NPINS-1:0] din_last,
  input logic [NPINS-1:0] mode_edge,
  input logic [NPINS-1:0] mode_any,
  input logic [NPINS-1:0] evt_en,
  input logic             clr_we,
  input logic [NPINS-1:0] clr_mask,
  input logic [NPINS-1:0] evt_stat,
  input logic             irq
);

  logic [NPINS-1:0] applied_clr;
  assign applied_clr = clr_we ? clr_mask : '0;

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (evt_stat == '0 && irq == 1'b0);
    end
  end

  assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(din_now) & ~$past(mode_edge) & ~evt_stat) == '0));

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(din_now) & ~$past(din_last) & $past(mode_edge) & ~evt_stat) == '0));

  assert_change_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(din_now) ^ $past(din_last)) & $past(mode_edge) & $past(mode_any)
               & ~evt_stat) == '0));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_stat) & ~$past(applied_clr) & ~evt_stat) == '0));

  assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(evt_stat & evt_en))));

  assert_no_enable_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_en) == '0) |-> !irq);

endmodule

bind gpio_event_detect gpio_event_detect_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .din_now(din_now), .din_last(din_last),
  .mode_edge(mode_edge), .mode_any(mode_any), .evt_en(evt_en),
  .clr_we(clr_we), .clr_mask(clr_mask), .evt_stat(evt_stat), .irq(irq)
);

// File: tb/sim_gpio_event_detect.sv
`timescale 1ns/1ps
module sim_gpio_event_detect;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] din_now = '0, din_last = '0, mode_edge = '0, mode_any = '0, evt_en = '0, clr_mask = '0;
  logic         clr_we = 1'b0;
  logic [N-1:0] evt_stat;
  logic         irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [N-1:0] m_stat = '0;
  logic         m_irq = 1'b0;

  always #2.5 clk = ~clk;

  gpio_event_detect #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .din_now(din_now), .din_last(din_last),
    .mode_edge(mode_edge), .mode_any(mode_any), .evt_en(evt_en),
    .clr_we(clr_we), .clr_mask(clr_mask), .evt_stat(evt_stat), .irq(irq)
  );

  function automatic logic [N-1:0] hits_of(logic [N-1:0] c, logic [N-1:0] p,
                                           logic [N-1:0] k, logic [N-1:0] b);
    logic [N-1:0] ch = c ^ p;
    return (c & ~k) | (k & b & ch) | (k & ch & c);
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic [N-1:0] nxt;
    nxt = (clr_we ? (m_stat & ~clr_mask) : m_stat) | hits_of(din_now, din_last, mode_edge, mode_any);
    m_irq = |(m_stat & evt_en);
    m_stat = nxt;
    @(posedge clk);
    @(negedge clk);
    chk(tag, evt_stat, m_stat);
    chk({tag, " irq"}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
  endtask

  task automatic quiet();
    clr_we = 1'b0; clr_mask = '0; din_last = din_now;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset stat", evt_stat, '0);
    chk("R1 reset irq", {31'b0, irq}, '0);
    rst_n = 1'b1;
    step("R1 first cycle");
    chk("R1 after release", evt_stat, '0);

    // level mode, bit0
    din_now = 32'h1; din_last = 32'h0;
    step("R2 level");
    chk("R2 level bit0", evt_stat & 32'h1, 32'h1);
    quiet(); clr_we = 1'b1; clr_mask = 32'h1;
    step("R7 reassert");
    chk("R7 bit0 stays", evt_stat & 32'h1, 32'h1);
    din_now = 32'h0; din_last = 32'h1; clr_we = 1'b1; clr_mask = 32'h1;
    step("R6 clear");
    chk("R6 bit0 cleared", evt_stat & 32'h1, 32'h0);

    // rising mode, bit1
    mode_edge = 32'h6; mode_any = 32'h4; quiet();
    din_now = 32'h2; din_last = 32'h0;
    step("R3 rise");
    chk("R3 rise sets bit1", evt_stat & 32'h2, 32'h2);
    quiet(); clr_we = 1'b1; clr_mask = 32'h2;
    step("R6 clear bit1");
    chk("R6 bit1 cleared", evt_stat & 32'h2, 32'h0);
    din_now = 32'h0; din_last = 32'h2; clr_we = 1'b0;
    step("R3 fall ignored");
    chk("R3 fall no set", evt_stat & 32'h2, 32'h0);

    // both-edge, bit2 falls
    din_now = 32'h0; din_last = 32'h4;
    step("R4 fall");
    chk("R4 fall sets bit2", evt_stat & 32'h4, 32'h4);
    quiet();
    for (int i = 0; i < 4; i++) begin
      din_now = 32'h4 * i[0]; din_last = din_now;
      step("R5 hold");
    end
    chk("R5 bit2 sticky", evt_stat & 32'h4, 32'h4);

    // clear and rise on bit1 together
    din_now = 32'h2; din_last = 32'h0; clr_we = 1'b1; clr_mask = 32'h2;
    step("R8 collide");
    quiet(); din_now = 32'h2; din_last = 32'h2;
    clr_we = 1'b1; clr_mask = 32'h2; step("R8 pre");
    din_now = 32'h0; din_last = 32'h0; clr_mask = 32'h2;
    din_now = 32'h2; step("R8 clear+rise");
    chk("R8 event wins", evt_stat & 32'h2, 32'h2);

    // interrupt
    quiet(); din_now = '0; din_last = '0;
    evt_en = 32'h0;
    step("R10 disabled");
    chk("R10 irq low", {31'b0, irq}, '0);
    evt_en = 32'h4;
    step("R9 enable");
    chk("R9 irq rises", {31'b0, irq}, 32'h1);
    clr_we = 1'b1; clr_mask = 32'h4;
    step("R9 clear edge");
    chk("R9 irq still high", {31'b0, irq}, 32'h1);
    quiet();
    step("R9 next edge");
    chk("R9 irq falls", {31'b0, irq}, 32'h0);

    // random
    for (int i = 0; i < 600; i++) begin
      din_last  = din_now;
      din_now   = $urandom & $urandom;
      mode_edge = (i % 50 == 0) ? $urandom : mode_edge;
      mode_any  = (i % 50 == 0) ? $urandom : mode_any;
      evt_en    = (i % 20 == 0) ? ($urandom & $urandom) : evt_en;
      clr_we    = $urandom_range(0, 2) != 0;
      clr_mask  = $urandom;
      step("R2 random");
    end
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
  end
endmodule